// File: doc/BRIEF.md
# Packed Lane Shift, Rotate and Permute Unit

This block is a one-stage datapath for a 64-bit packed-data pipeline. It treats its main operand as a set of equal lanes of 16, 32 or 64 bits and applies a logical or arithmetic shift, or a rotate, inside each lane. It can also rearrange the four halfwords of the operand under an 8-bit selector. A third mode extracts a 64-bit window at any byte offset from the pair of operands.

Each operation also produces a status word. The word carries a negative flag and a zero flag for every lane of the result. The caller presents one operation with `in_valid`. The result and the status word appear one clock later and stay in place until the next valid operation.

Top module: `pshf_unit`

## Requirements
- R1: While `rst` is high and after its release, `out_valid` is 0 and both `result` and `flags` are 0 until the first valid operation.
- R2: An operation presented with `in_valid` high appears on `result` and `flags` on the next clock, with `out_valid` high in that cycle only. While `in_valid` is low, `result` and `flags` hold their values.
- R3: Left shift (opcode 0) and logical right shift (opcode 1) act within each lane. Bits leaving a lane are lost and vacated bits are zero. An `amt` equal to or above the lane width gives a zero lane.
- R4: Arithmetic right shift (opcode 2) fills each lane from its own top bit. An `amt` equal to or above the lane width gives a lane made entirely of copies of that bit.
- R5: Rotate right (opcode 3) turns each lane right by `amt` modulo the lane width, so bits leaving the bottom of a lane re-enter at its top.
- R6: Halfword shuffle (opcode 4) fills destination halfword k (bits 16k+15..16k) with source halfword `amt[2k+1:2k]` of `opa`. The status word uses 16-bit lanes.
- R7: Byte align (opcode 5) returns bits 8n+63..8n of the concatenation {`opb`,`opa`}, where n = `amt[2:0]`. With n = 0 it returns `opa`. It uses 64-bit status. `opb` has no effect on any other opcode.
- R8: The status word for lane i of width W puts the lane's top bit at bit (i+1)*W/2-1 and a lane-is-zero flag at bit (i+1)*W/2-2. That is bits 8i+7/8i+6 for 16-bit lanes, 16i+15/16i+14 for 32-bit lanes and 31/30 for one 64-bit lane. All other bits are 0.
- R9: `lane_sel` 0, 1 and 2 select 16-, 32- and 64-bit lanes, and 3 behaves as 2. Opcodes 6 and 7 pass `opa` through with 64-bit status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 3 | Operation select |
| lane_sel | input | 2 | Lane width for shifts and rotates |
| opa | input | 64 | Main data operand |
| opb | input | 64 | Upper half of the align window |
| amt | input | 8 | Shift/rotate count, shuffle selector or align byte count |
| out_valid | output | 1 | Result and status updated |
| result | output | 64 | Operation result |
| flags | output | 32 | Per-lane negative and zero flags |

## Verification
The bench builds the unit with its default 64-bit data path and 8-bit amount field. At that size every count from 0 past the widest lane, plus large counts such as 128 and 255, is swept for each shift kind and lane width. All 256 shuffle selectors and all eight align offsets are also covered. Expected results and status words are derived per lane in the bench from the lane width, so zero lanes, sign-filled lanes and the boundary between in-range and oversized counts are all exercised.

// File: rtl/pshf_pkg.sv
package pshf_pkg;
  typedef enum logic [2:0] {
    OP_SHL   = 3'd0,
    OP_SHR   = 3'd1,
    OP_SAR   = 3'd2,
    OP_ROR   = 3'd3,
    OP_SHUF  = 3'd4,
    OP_ALIGN = 3'd5,
    OP_PASS6 = 3'd6,
    OP_PASS7 = 3'd7
  } pshf_op_e;

  typedef enum logic [1:0] {
    K_SHL = 2'd0,
    K_SHR = 2'd1,
    K_SAR = 2'd2,
    K_ROR = 2'd3
  } shift_kind_e;

  localparam int NUM_SIZES = 3;
endpackage

// File: rtl/pshf_lane_alu.sv
module pshf_lane_alu #(
  parameter int W     = 16,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     x,
  input  logic [1:0]       kind,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     y
);
  localparam int SW = $clog2(W);

  logic          big;
  logic [SW-1:0] sh;
  logic [SW-1:0] sa;
  logic [2*W-1:0] dbl;

  always_comb begin
    big = ({1'b0, amt} >= (AMT_W+1)'(W));
    sh  = amt[SW-1:0];
    sa  = big ? SW'(W-1) : sh;
    dbl = {x, x} >> sh;
    case (kind)
      2'd0:    y = big ? '0 : (x << sh);
      2'd1:    y = big ? '0 : (x >> sh);
      2'd2:    y = W'($signed(x) >>> sa);
      default: y = dbl[W-1:0];
    endcase
  end
endmodule

// File: rtl/pshf_lane_bank.sv
module pshf_lane_bank #(
  parameter int DATA_W = 64,
  parameter int W      = 16,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] x,
  input  logic [1:0]        kind,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] y
);
  localparam int NL = DATA_W / W;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    pshf_lane_alu #(.W(W), .AMT_W(AMT_W)) u_alu (
      .x   (x[l*W +: W]),
      .kind(kind),
      .amt (amt),
      .y   (y[l*W +: W])
    );
  end
endmodule

// File: rtl/pshf_permute.sv
module pshf_permute #(
  parameter int DATA_W = 64,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] shuf_y,
  output logic [DATA_W-1:0] align_y
);
  localparam int HW    = DATA_W / 4;
  localparam int NBYTE = DATA_W / 8;
  localparam int BSW   = $clog2(NBYTE);

  logic [2*DATA_W-1:0] win;

  for (genvar k = 0; k < 4; k++) begin : g_half
    logic [1:0] src;
    assign src = amt[2*k +: 2];
    assign shuf_y[k*HW +: HW] = a[src*HW +: HW];
  end

  always_comb begin
    win     = {b, a} >> ({amt[BSW-1:0], 3'b000});
    align_y = win[DATA_W-1:0];
  end
endmodule

// File: rtl/pshf_flags.sv
module pshf_flags #(
  parameter int DATA_W = 64,
  parameter int FLAG_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] res,
  input  logic [1:0]        size_idx,
  output logic [FLAG_W-1:0] flags
);
  localparam int HW = DATA_W / 4;

  logic [FLAG_W-1:0] by_size [pshf_pkg::NUM_SIZES];

  for (genvar s = 0; s < pshf_pkg::NUM_SIZES; s++) begin : g_sz
    localparam int W  = HW << s;
    localparam int NL = DATA_W / W;
    always_comb begin
      by_size[s] = '0;
      for (int l = 0; l < NL; l++) begin
        by_size[s][(l+1)*W/2-1] = res[l*W+W-1];
        by_size[s][(l+1)*W/2-2] = (res[l*W +: W] == '0);
      end
    end
  end

  always_comb begin
    case (size_idx)
      2'd0:    flags = by_size[0];
      2'd1:    flags = by_size[1];
      default: flags = by_size[2];
    endcase
  end
endmodule

// File: rtl/pshf_unit.sv
module pshf_unit #(
  parameter int DATA_W = 64,
  parameter int AMT_W  = 8,
  parameter int FLAG_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        opcode,
  input  logic [1:0]        lane_sel,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [AMT_W-1:0]  amt,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);
  import pshf_pkg::*;

  localparam int HW = DATA_W / 4;

  logic [DATA_W-1:0] bank_y [NUM_SIZES];
  logic [DATA_W-1:0] shuf_y, align_y, nxt_res;
  logic [FLAG_W-1:0] nxt_flags;
  logic [1:0]        lane_idx, flag_idx;
  pshf_op_e          op;

  assign op       = pshf_op_e'(opcode);
  assign lane_idx = (lane_sel == 2'd3) ? 2'd2 : lane_sel;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_bank
    pshf_lane_bank #(.DATA_W(DATA_W), .W(HW << s), .AMT_W(AMT_W)) u_bank (
      .x   (opa),
      .kind(opcode[1:0]),
      .amt (amt),
      .y   (bank_y[s])
    );
  end

  pshf_permute #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_perm (
    .a      (opa),
    .b      (opb),
    .amt    (amt),
    .shuf_y (shuf_y),
    .align_y(align_y)
  );

  always_comb begin
    case (op)
      OP_SHL, OP_SHR, OP_SAR, OP_ROR: begin
        flag_idx = lane_idx;
        case (lane_idx)
          2'd0:    nxt_res = bank_y[0];
          2'd1:    nxt_res = bank_y[1];
          default: nxt_res = bank_y[2];
        endcase
      end
      OP_SHUF: begin
        flag_idx = 2'd0;
        nxt_res  = shuf_y;
      end
      OP_ALIGN: begin
        flag_idx = 2'd2;
        nxt_res  = align_y;
      end
      default: begin
        flag_idx = 2'd2;
        nxt_res  = opa;
      end
    endcase
  end

  pshf_flags #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_flags (
    .res     (nxt_res),
    .size_idx(flag_idx),
    .flags   (nxt_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        flags  <= nxt_flags;
      end
    end
  end
endmodule

// File: rtl/pshf_unit_chk.sv
module pshf_unit_chk #(
  parameter int DATA_W = 64,
  parameter int AMT_W  = 8,
  parameter int FLAG_W = DATA_W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        opcode,
  input logic [1:0]        lane_sel,
  input logic [DATA_W-1:0] opa,
  input logic [AMT_W-1:0]  amt,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [FLAG_W-1:0] flags
);
  localparam int HW = DATA_W / 4;

  function automatic logic [FLAG_W-1:0] used_bits();
    logic [FLAG_W-1:0] m = '0;
    for (int l = 0; l < 4; l++) begin
      m[(l+1)*HW/2-1] = 1'b1;
      m[(l+1)*HW/2-2] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [FLAG_W-1:0] USED = used_bits();

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flags)));
  p_shl_big_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 3'd0 && amt >= AMT_W'(DATA_W)) |=> (result == '0));
  p_ror_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 3'd3 && amt == '0) |=> (result == $past(opa)));
  p_align_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 3'd5 && amt[2:0] == 3'd0) |=> (result == $past(opa)));
  p_flag64_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode[2] == 1'b0 && lane_sel[1]) |=>
      (flags[FLAG_W-1] == result[DATA_W-1] && flags[FLAG_W-2] == (result == '0)));
  p_flag_bits_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((flags & ~USED) == '0));
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && result == '0 && flags == '0));
endmodule

bind pshf_unit pshf_unit_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W), .FLAG_W(FLAG_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .opcode   (opcode),
  .lane_sel (lane_sel),
  .opa      (opa),
  .amt      (amt),
  .out_valid(out_valid),
  .result   (result),
  .flags    (flags)
);

// File: tb/tb_pshf_unit.sv
module tb_pshf_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  opcode = '0;
  logic [1:0]  lane_sel = '0;
  logic [63:0] opa = '0, opb = '0;
  logic [7:0]  amt = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [31:0] flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pshf_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .lane_sel(lane_sel), .opa(opa), .opb(opb), .amt(amt),
    .out_valid(out_valid), .result(result), .flags(flags)
  );

  function automatic int lane_w(int op, int sz);
    if (op == 4) return 16;
    if (op >= 5) return 64;
    return (sz >= 2) ? 64 : (16 << sz);
  endfunction

  function automatic logic [63:0] wmask(int w);
    return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] ref_res(int op, int sz, logic [63:0] a,
                                          logic [63:0] b, int n);
    logic [63:0]  r = '0;
    logic [127:0] cat;
    int w = lane_w(op, sz);
    logic [63:0] m = wmask(w);
    if (op == 4) begin
      for (int k = 0; k < 4; k++) begin
        int s = (n >> (2*k)) & 3;
        r[16*k +: 16] = a[16*s +: 16];
      end
    end else if (op == 5) begin
      cat = {b, a} >> (8 * (n & 7));
      r = cat[63:0];
    end else if (op >= 6) begin
      r = a;
    end else begin
      for (int l = 0; l < 64 / w; l++) begin
        logic [63:0] x = (a >> (l*w)) & m;
        logic [63:0] y;
        logic sgn = x[w-1];
        case (op)
          0: y = (n >= w) ? 64'd0 : (x << n);
          1: y = (n >= w) ? 64'd0 : (x >> n);
          2: y = (n >= w) ? (sgn ? m : 64'd0)
                          : ((x >> n) | (sgn ? (m & ~(m >> n)) : 64'd0));
          default: begin
            int rr = n % w;
            y = (rr == 0) ? x : ((x >> rr) | (x << (w - rr)));
          end
        endcase
        r = r | ((y & m) << (l*w));
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_flags(int op, int sz, logic [63:0] r);
    logic [31:0] f = '0;
    int w = lane_w(op, sz);
    logic [63:0] m = wmask(w);
    for (int l = 0; l < 64 / w; l++) begin
      logic [63:0] ln = (r >> (l*w)) & m;
      f[(l+1)*w/2-1] = ln[w-1];
      f[(l+1)*w/2-2] = (ln == 64'd0);
    end
    return f;
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(int op, int sz, logic [63:0] a, logic [63:0] b, int n,
                     string req = "");
    logic [63:0] er;
    string t = (req == "") ? tag_of(op) : req;
    @(negedge clk);
    opcode = 3'(op); lane_sel = 2'(sz); opa = a; opb = b; amt = 8'(n);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    er = ref_res(op, sz, a, b, n);
    check64(t, result, er);
    check64("R8", {32'd0, flags}, {32'd0, ref_flags(op, sz, er)});
    check64("R2", {63'd0, out_valid}, 64'd1);
  endtask

  logic [63:0] pats [4];

  initial begin
    logic [63:0] held_r;
    logic [31:0] held_f;
    pats[0] = 64'h8001_7FFE_0000_F00F;
    pats[1] = 64'hFFFF_FFFF_0000_0000;
    pats[2] = 64'h0123_4567_89AB_CDEF;
    pats[3] = 64'h8000_0000_0000_0001;

    repeat (3) @(negedge clk);
    // R1: reset state
    check64("R1", {63'd0, out_valid}, 64'd0);
    check64("R1", result, 64'd0);
    check64("R1", {32'd0, flags}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check64("R1", {63'd0, out_valid}, 64'd0);
    check64("R1", result, 64'd0);

    // R3 R4 R5: shifts and rotates over every lane width and count
    for (int op = 0; op < 4; op++)
      for (int sz = 0; sz < 3; sz++)
        for (int p = 0; p < 4; p++) begin
          for (int n = 0; n <= 66; n++) run(op, sz, pats[p], ~pats[p], n);
          run(op, sz, pats[p], 64'd0, 128);
          run(op, sz, pats[p], 64'd0, 255);
        end

    // R9: lane_sel 3 behaves as 64-bit lanes
    for (int op = 0; op < 4; op++)
      for (int n = 0; n < 70; n += 7) run(op, 3, pats[2], 64'd0, n, "R9");

    // R6: every shuffle selector
    for (int c = 0; c < 256; c++) run(4, c % 4, pats[c % 4], pats[(c+1) % 4], c);

    // R7: every byte offset, upper amount bits ignored
    for (int p = 0; p < 4; p++)
      for (int n = 0; n < 8; n++) begin
        run(5, 0, pats[p], pats[(p+2) % 4], n);
        run(5, 1, pats[p], pats[(p+1) % 4], n | 8'hA8);
      end

    // R7: opb has no effect on a shift result
    run(1, 0, pats[2], 64'hDEAD_BEEF_0BAD_F00D, 3, "R7");
    run(1, 0, pats[2], 64'h0, 3, "R7");

    // R9: pass-through opcodes
    for (int p = 0; p < 4; p++) begin
      run(6, 0, pats[p], 64'd0, 5);
      run(7, 1, pats[p], 64'd0, 9);
    end

    // R8: all-zero operand sets every zero flag
    for (int sz = 0; sz < 3; sz++) run(0, sz, 64'd0, 64'd0, 1, "R8");

    // R2: outputs hold while in_valid is low
    run(2, 0, pats[0], 64'd0, 4);
    held_r = result; held_f = flags;
    @(negedge clk);
    opcode = 3'd0; opa = 64'h5555_5555_5555_5555; amt = 8'd1; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check64("R2", result, held_r);
    check64("R2", {32'd0, flags}, {32'd0, held_f});
    check64("R2", {63'd0, out_valid}, 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule